// File: doc/BRIEF.md
# Hidden Configuration Register Unlock Window

This block sits between a host bus and a disk drive's task-file port. The controller behind it keeps a small set of configuration registers: two timing banks of read and write cycle timing, a control byte, a misc byte and a read-only strap byte that reports a silicon version. These registers sit at the same byte offsets as the drive's task-file registers. A normal host access must not reach them by chance, so the offset space is shared through a key sequence. The host makes two 16-bit reads at offset 1 and then a byte write of 0x03 at offset 2. That opens a window in which byte accesses at the configuration offsets go to the internal registers and not to the drive. A byte write of 0x83 at offset 2 closes the window again. The channel base address (0x1F0 on the primary channel, 0x170 on the secondary) is decoded upstream, so the block sees only the low offset.

There is one access per clock cycle, marked by a read or write strobe. The block answers in the same cycle: a pass-through enable that forwards the access to the drive, read data for intercepted reads, and one write enable per configuration slot. The write data is taken from the host bus. A byte write of 0xC0 at offset 3 while the window is closed arms the second timing bank. From then on, bit 0 of the misc register chooses which bank the timing offsets reach.

Top module: `cfgwin_unlock`

## Requirements
- R1: After reset the window is closed, the key sequence is idle, the second bank is unarmed and every stored register reads 0. The first access after reset is passed to the drive with read data 0.
- R2: Two 16-bit reads at offset 1 followed by a byte write of 0x03 at offset 2 open the window. The next byte read at offset 5 then returns the strap version (default 0) and is not passed to the drive.
- R3: The three key accesses are themselves passed to the drive, because the window is not yet open while they occur.
- R4: Any access that is not the expected next key step returns the sequence to idle, and only a fresh, complete sequence opens the window. Such an access is a read of the wrong size or offset, a wrong key value, an extra third read, or any write before the key.
- R5: While open, byte accesses at offsets 0, 1, 3, 5 and 6 are intercepted (pass enable low). Writes there are stored, and reads there return the stored value.
- R6: While open, byte accesses at offsets 4 and 7, all 16-bit accesses, reads at offset 2 and writes at offset 2 of any value other than 0x83 pass to the drive, and the window stays open.
- R7: While open, a byte write of 0x83 at offset 2 is not forwarded and closes the window. Later accesses pass to the drive, and the stored values survive for the next opening.
- R8: The strap slot at offset 5 is read-only. A write to it raises no write enable, and later reads still return the version.
- R9: A byte write of 0xC0 at offset 3 while closed is forwarded, arms the second bank and also counts as a key deviation. Once the bank is armed, misc bit 0 = 1 steers offsets 0 and 1 to the second timing bank. When the bank is unarmed, misc bit 0 has no effect.
- R10: Write enable bit encoding: bit 0 = read timing bank A, bit 1 = write timing bank A, bit 2 = read timing bank B, bit 3 = write timing bank B, bit 4 = control, bit 5 = misc. At most one bit is high, and only in the cycle of the intercepted write.
- R11: Cycles with neither strobe neither advance nor reset the key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe, one access per cycle |
| wr_i | input | 1 | Write strobe; with rd_i also high the cycle is a write |
| wide_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| off_i | input | 3 | Offset from the channel base |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Configuration read data, 0 unless an intercepted read |
| cfg_we_o | output | 6 | Per-slot write enables (encoding in R10) |
| pass_o | output | 1 | Forward this access to the drive interface |

## Verification
Two functions can fall in the same cycle: a byte write of 0xC0 at offset 3 arms the second bank, and the same write also breaks a key sequence that had reached its last step. The bench provokes this by making both 16-bit reads, then writing 0xC0 at offset 3, then writing 0x03 at offset 2. It judges the result in two ways. First, the 0x03 write must still be forwarded and a following offset 0 read must pass, so the window did not open. Second, a later full unlock with misc bit 0 set must steer timing writes to write enable bits 2 and 3, which shows the arming took effect.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ONE, SQ_TWO, SQ_OPEN} seq_e;

  localparam int NSLOT   = 6;
  localparam int SL_RT_A = 0;
  localparam int SL_WT_A = 1;
  localparam int SL_RT_B = 2;
  localparam int SL_WT_B = 3;
  localparam int SL_CTRL = 4;
  localparam int SL_MISC = 5;
endpackage

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
  import cfgwin_pkg::*;
#(
  parameter int          OFF_W      = 3,
  parameter int          DATA_W     = 8,
  parameter int          UNLOCK_OFF = 1,
  parameter int          KEY_OFF    = 2,
  parameter logic [7:0]  OPEN_KEY   = 8'h03,
  parameter logic [7:0]  CLOSE_KEY  = 8'h83
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o,
  output logic              close_o
);
  seq_e state_q, state_d;
  logic acc, step_rd, step_key;

  assign acc      = rd_i | wr_i;
  assign step_rd  = rd_i & ~wr_i & wide_i & (off_i == OFF_W'(UNLOCK_OFF));
  assign step_key = wr_i & ~wide_i & (off_i == OFF_W'(KEY_OFF)) &
                    (wdata_i == DATA_W'(OPEN_KEY));
  assign open_o   = (state_q == SQ_OPEN);
  assign close_o  = open_o & wr_i & ~wide_i & (off_i == OFF_W'(KEY_OFF)) &
                    (wdata_i == DATA_W'(CLOSE_KEY));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (acc) state_d = step_rd  ? SQ_ONE  : SQ_IDLE;
      SQ_ONE:  if (acc) state_d = step_rd  ? SQ_TWO  : SQ_IDLE;
      SQ_TWO:  if (acc) state_d = step_key ? SQ_OPEN : SQ_IDLE;
      SQ_OPEN: if (close_o) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;

  p_key_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_TWO && step_key) |=> open_o);
  p_deviate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_ONE && acc && !step_rd) |=> state_q == SQ_IDLE);
  p_close_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> !open_o);
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |=> $stable(state_q));
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int         OFF_W     = 3,
  parameter int         DATA_W    = 8,
  parameter int         RT_OFF    = 0,
  parameter int         WT_OFF    = 1,
  parameter int         CTRL_OFF  = 3,
  parameter int         STRAP_OFF = 5,
  parameter int         MISC_OFF  = 6,
  parameter logic [7:0] BANK_KEY  = 8'hC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              close_i,
  input  logic              bank_sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_rd_o,
  output logic              arm_o,
  output logic              pass_o,
  output logic [NSLOT-1:0]  we_o
);
  logic cfg_off, hit;

  assign cfg_off = (off_i == OFF_W'(RT_OFF))    | (off_i == OFF_W'(WT_OFF)) |
                   (off_i == OFF_W'(CTRL_OFF))  | (off_i == OFF_W'(STRAP_OFF)) |
                   (off_i == OFF_W'(MISC_OFF));
  assign hit      = open_i & ~wide_i & cfg_off & (rd_i | wr_i);
  assign hit_rd_o = hit & ~wr_i;
  assign pass_o   = (rd_i | wr_i) & ~hit & ~close_i;
  assign arm_o    = ~open_i & wr_i & ~wide_i & (off_i == OFF_W'(CTRL_OFF)) &
                    (wdata_i == DATA_W'(BANK_KEY));

  always_comb begin
    we_o = '0;
    if (hit && wr_i) begin
      if (off_i == OFF_W'(RT_OFF))   we_o[bank_sel_i ? SL_RT_B : SL_RT_A] = 1'b1;
      if (off_i == OFF_W'(WT_OFF))   we_o[bank_sel_i ? SL_WT_B : SL_WT_A] = 1'b1;
      if (off_i == OFF_W'(CTRL_OFF)) we_o[SL_CTRL] = 1'b1;
      if (off_i == OFF_W'(MISC_OFF)) we_o[SL_MISC] = 1'b1;
    end
  end

  p_close_no_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |-> !pass_o && we_o == '0);
  p_we_needs_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o != '0) |-> open_i && !pass_o);
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int         OFF_W     = 3,
  parameter int         DATA_W    = 8,
  parameter int         RT_OFF    = 0,
  parameter int         WT_OFF    = 1,
  parameter int         CTRL_OFF  = 3,
  parameter int         STRAP_OFF = 5,
  parameter int         MISC_OFF  = 6,
  parameter logic [7:0] STRAP_VER = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSLOT-1:0]  we_i,
  input  logic              arm_i,
  input  logic              hit_rd_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              bank_sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_q [NSLOT];
  logic              bank_en_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)    slot_q[g] <= '0;
      else if (we_i[g]) slot_q[g] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    bank_en_q <= 1'b0;
    else if (arm_i) bank_en_q <= 1'b1;

  assign bank_sel_o = bank_en_q & slot_q[SL_MISC][0];

  always_comb begin
    rdata_o = '0;
    if (hit_rd_i) begin
      if (off_i == OFF_W'(RT_OFF))    rdata_o = slot_q[bank_sel_o ? SL_RT_B : SL_RT_A];
      if (off_i == OFF_W'(WT_OFF))    rdata_o = slot_q[bank_sel_o ? SL_WT_B : SL_WT_A];
      if (off_i == OFF_W'(CTRL_OFF))  rdata_o = slot_q[SL_CTRL];
      if (off_i == OFF_W'(STRAP_OFF)) rdata_o = DATA_W'(STRAP_VER);
      if (off_i == OFF_W'(MISC_OFF))  rdata_o = slot_q[SL_MISC];
    end
  end

  p_bank_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_en_q |=> bank_en_q);
  p_strap_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_rd_i && off_i == OFF_W'(STRAP_OFF)) |-> rdata_o == DATA_W'(STRAP_VER));
endmodule

// File: rtl/cfgwin_unlock.sv
module cfgwin_unlock
  import cfgwin_pkg::*;
#(
  parameter int         OFF_W      = 3,
  parameter int         DATA_W     = 8,
  parameter int         UNLOCK_OFF = 1,
  parameter int         KEY_OFF    = 2,
  parameter int         RT_OFF     = 0,
  parameter int         WT_OFF     = 1,
  parameter int         CTRL_OFF   = 3,
  parameter int         STRAP_OFF  = 5,
  parameter int         MISC_OFF   = 6,
  parameter logic [7:0] OPEN_KEY   = 8'h03,
  parameter logic [7:0] CLOSE_KEY  = 8'h83,
  parameter logic [7:0] BANK_KEY   = 8'hC0,
  parameter logic [7:0] STRAP_VER  = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NSLOT-1:0]  cfg_we_o,
  output logic              pass_o
);
  logic open, close, bank_sel, hit_rd, arm;

  cfgwin_seq #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .UNLOCK_OFF(UNLOCK_OFF), .KEY_OFF(KEY_OFF),
    .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY)
  ) u_seq (
    .clk_i, .rst_ni, .rd_i, .wr_i, .wide_i, .off_i, .wdata_i,
    .open_o(open), .close_o(close)
  );

  cfgwin_decode #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .RT_OFF(RT_OFF), .WT_OFF(WT_OFF),
    .CTRL_OFF(CTRL_OFF), .STRAP_OFF(STRAP_OFF), .MISC_OFF(MISC_OFF),
    .BANK_KEY(BANK_KEY)
  ) u_dec (
    .clk_i, .rst_ni, .open_i(open), .close_i(close), .bank_sel_i(bank_sel),
    .rd_i, .wr_i, .wide_i, .off_i, .wdata_i,
    .hit_rd_o(hit_rd), .arm_o(arm), .pass_o, .we_o(cfg_we_o)
  );

  cfgwin_regs #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .RT_OFF(RT_OFF), .WT_OFF(WT_OFF),
    .CTRL_OFF(CTRL_OFF), .STRAP_OFF(STRAP_OFF), .MISC_OFF(MISC_OFF),
    .STRAP_VER(STRAP_VER)
  ) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_o), .arm_i(arm), .hit_rd_i(hit_rd),
    .off_i, .wdata_i, .bank_sel_o(bank_sel), .rdata_o
  );

  p_we_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_we_o));
  p_we_only_on_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_o != '0) |-> wr_i);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> !pass_o && cfg_we_o == '0 && rdata_o == '0);
endmodule

// File: tb/cfgwin_unlock_test.sv
module cfgwin_unlock_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] req;
    logic       rd, wr, wide;
    logic [2:0] off;
    logic [7:0] wd;
    logic       pass;
    logic [7:0] rdat;
    logic [5:0] we;
  } vec_t;

  function automatic vec_t v(int req, bit rd, bit wr, bit wide, int off,
                             logic [7:0] wd, bit pass, logic [7:0] rdat,
                             logic [5:0] we);
    vec_t t;
    t.req = 4'(req); t.rd = rd; t.wr = wr; t.wide = wide; t.off = 3'(off);
    t.wd = wd; t.pass = pass; t.rdat = rdat; t.we = we;
    return t;
  endfunction

  localparam int N = 61;
  //                 req rd wr wd off data  pass rdata we
  localparam vec_t TBL [N] = '{
    v(1, 1,0,0, 0, 8'h00, 1, 8'h00, 6'h00), // R1 closed after reset
    v(3, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00), // R3 key read 1
    v(3, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00), // R3 key read 2
    v(3, 0,1,0, 2, 8'h03, 1, 8'h00, 6'h00), // R3 key write forwarded
    v(2, 1,0,0, 5, 8'h00, 0, 8'h00, 6'h00), // R2 strap version, intercepted
    v(5, 0,1,0, 0, 8'h25, 0, 8'h00, 6'h01), // R5 read timing A
    v(10,0,1,0, 1, 8'h31, 0, 8'h00, 6'h02), // R10 write timing A
    v(5, 0,1,0, 3, 8'h85, 0, 8'h00, 6'h10), // R5 control
    v(10,0,1,0, 6, 8'h40, 0, 8'h00, 6'h20), // R10 misc
    v(5, 1,0,0, 0, 8'h00, 0, 8'h25, 6'h00), // R5 readback
    v(5, 1,0,0, 1, 8'h00, 0, 8'h31, 6'h00),
    v(5, 1,0,0, 3, 8'h00, 0, 8'h85, 6'h00),
    v(5, 1,0,0, 6, 8'h00, 0, 8'h40, 6'h00),
    v(8, 0,1,0, 5, 8'h7E, 0, 8'h00, 6'h00), // R8 strap write dropped
    v(8, 1,0,0, 5, 8'h00, 0, 8'h00, 6'h00), // R8 strap unchanged
    v(6, 1,0,0, 4, 8'h00, 1, 8'h00, 6'h00), // R6 offset 4 passes
    v(6, 1,0,1, 0, 8'h00, 1, 8'h00, 6'h00), // R6 16-bit passes
    v(6, 0,1,0, 2, 8'h12, 1, 8'h00, 6'h00), // R6 other offset-2 value
    v(6, 1,0,0, 2, 8'h00, 1, 8'h00, 6'h00), // R6 offset-2 read
    v(6, 1,0,0, 0, 8'h00, 0, 8'h25, 6'h00), // R6 window still open
    v(7, 0,1,0, 2, 8'h83, 0, 8'h00, 6'h00), // R7 close not forwarded
    v(7, 1,0,0, 0, 8'h00, 1, 8'h00, 6'h00), // R7 closed
    v(4, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00), // R4 wrong size
    v(4, 1,0,0, 1, 8'h00, 1, 8'h00, 6'h00),
    v(4, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00),
    v(4, 0,1,0, 2, 8'h03, 1, 8'h00, 6'h00),
    v(4, 1,0,0, 0, 8'h00, 1, 8'h00, 6'h00), // R4 not open
    v(11,1,0,1, 1, 8'h00, 1, 8'h00, 6'h00), // R11 gaps in sequence
    v(11,0,0,0, 1, 8'h00, 0, 8'h00, 6'h00),
    v(11,0,0,0, 2, 8'h03, 0, 8'h00, 6'h00),
    v(11,1,0,1, 1, 8'h00, 1, 8'h00, 6'h00),
    v(11,0,1,0, 2, 8'h03, 1, 8'h00, 6'h00),
    v(11,1,0,0, 3, 8'h00, 0, 8'h85, 6'h00), // R11 opened, R7 kept value
    v(7, 0,1,0, 2, 8'h83, 0, 8'h00, 6'h00),
    v(4, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00), // R4 third read
    v(4, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00),
    v(4, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00),
    v(4, 0,1,0, 2, 8'h03, 1, 8'h00, 6'h00),
    v(4, 1,0,0, 0, 8'h00, 1, 8'h00, 6'h00),
    v(4, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00), // R4 wrong key value
    v(4, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00),
    v(4, 0,1,0, 2, 8'h04, 1, 8'h00, 6'h00),
    v(4, 0,1,0, 2, 8'h03, 1, 8'h00, 6'h00),
    v(4, 1,0,0, 0, 8'h00, 1, 8'h00, 6'h00),
    v(9, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00), // R9 arm inside sequence
    v(9, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00),
    v(9, 0,1,0, 3, 8'hC0, 1, 8'h00, 6'h00),
    v(9, 0,1,0, 2, 8'h03, 1, 8'h00, 6'h00),
    v(9, 1,0,0, 0, 8'h00, 1, 8'h00, 6'h00), // R9 did not open
    v(2, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00),
    v(2, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00),
    v(2, 0,1,0, 2, 8'h03, 1, 8'h00, 6'h00),
    v(9, 0,1,0, 6, 8'h01, 0, 8'h00, 6'h20), // R9 select bank B
    v(9, 0,1,0, 0, 8'h5A, 0, 8'h00, 6'h04),
    v(9, 0,1,0, 1, 8'h6B, 0, 8'h00, 6'h08),
    v(9, 1,0,0, 0, 8'h00, 0, 8'h5A, 6'h00),
    v(9, 1,0,0, 1, 8'h00, 0, 8'h6B, 6'h00),
    v(9, 0,1,0, 6, 8'h00, 0, 8'h00, 6'h20), // R9 back to bank A
    v(9, 1,0,0, 0, 8'h00, 0, 8'h25, 6'h00),
    v(9, 1,0,0, 1, 8'h00, 0, 8'h31, 6'h00),
    v(7, 0,1,0, 2, 8'h83, 0, 8'h00, 6'h00)
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_i = 1'b0, wr_i = 1'b0, wide_i = 1'b0;
  logic [2:0] off_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [5:0] cfg_we_o;
  logic       pass_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgwin_unlock uut (
    .clk_i(clk), .rst_ni, .rd_i, .wr_i, .wide_i, .off_i, .wdata_i,
    .rdata_o, .cfg_we_o, .pass_o
  );

  task automatic run(input vec_t t);
    @(negedge clk);
    rd_i = t.rd; wr_i = t.wr; wide_i = t.wide; off_i = t.off; wdata_i = t.wd;
    #2;
    checks++;
    if (pass_o !== t.pass || rdata_o !== t.rdat || cfg_we_o !== t.we) begin
      errors++;
      $display("FAIL R%0d off=%0d: pass=%b rdata=%h we=%h expected pass=%b rdata=%h we=%h",
               t.req, t.off, pass_o, rdata_o, cfg_we_o, t.pass, t.rdat, t.we);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < N; i++) run(TBL[i]);

    // R1: reset while open closes the window and clears registers
    run(v(2, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00));
    run(v(2, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00));
    run(v(2, 0,1,0, 2, 8'h03, 1, 8'h00, 6'h00));
    run(v(1, 0,0,0, 0, 8'h00, 0, 8'h00, 6'h00));
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    run(v(1, 1,0,0, 0, 8'h00, 1, 8'h00, 6'h00));
    run(v(1, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00));
    run(v(1, 1,0,1, 1, 8'h00, 1, 8'h00, 6'h00));
    run(v(1, 0,1,0, 2, 8'h03, 1, 8'h00, 6'h00));
    run(v(1, 1,0,0, 1, 8'h00, 0, 8'h00, 6'h00)); // R1 timing cleared
    run(v(1, 1,0,0, 3, 8'h00, 0, 8'h00, 6'h00));
    // R9: unarmed bank ignores misc bit 0
    run(v(9, 0,1,0, 6, 8'h01, 0, 8'h00, 6'h20));
    run(v(9, 0,1,0, 0, 8'h11, 0, 8'h00, 6'h01));
    run(v(9, 1,0,0, 0, 8'h00, 0, 8'h11, 6'h00));
    run(v(7, 0,1,0, 2, 8'h83, 0, 8'h00, 6'h00));
    run(v(11,0,0,0, 0, 8'h00, 0, 8'h00, 6'h00));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule